// File: doc/BRIEF.md
# Ordered Miss and Write-Buffer Issue Controller

This block sits between a data cache's request side and the next memory level. It keeps two queues of outstanding work. The miss queue takes cached read misses, cached write misses and uncached reads. The write queue takes uncached writes and writebacks of dirty evicted lines. Each accepted request gets a wrapping sequence number. Cached requests to a line that already has a waiting cached miss entry are folded into that entry, so one lower-level access serves all of them.

Each cycle an arbiter picks one of three selections: `SRC_NONE` (nothing can go), `SRC_MSHR` (the miss-queue head) or `SRC_WBUF` (the write-queue head). The choice follows three rules. The miss queue is preferred. The write queue goes first when it is full. No head may pass an older entry for the same line that waits in the other queue. The chosen entry appears on the issue port and is removed when the lower level raises `iss_ready`. A registered `req_blocked` flag stops the request side when either queue is full or when a miss entry has collected the maximum number of merged targets.

Top module: `miss_issue_ctrl`

## Requirements
- R1: Each accepted request gets the next sequence number. Numbers start at 0 after reset, step by one for each accepted request modulo 2^ORD_W, and are not used up by rejected requests.
- R2: `req_kind` codes are 0 cached read, 1 cached write, 2 uncached read, 3 uncached write and 4 writeback. Codes 0 to 2 enter the miss queue and issue with `iss_write`=0. Codes 3 and 4 enter the write queue and issue with `iss_write`=1. Codes 5 to 7 are dropped and take no sequence number.
- R3: A cached read or write whose line matches a waiting cached miss entry with fewer than TGT_MAX targets joins that entry. `iss_tgts` then counts the merged requests, and the entry keeps the sequence number of its first request. A merge is refused while the write queue holds the same line.
- R4: Each queue issues its own entries in arrival order.
- R5: When both queue heads may issue, the miss-queue head goes first unless the write queue is full.
- R6: A head never issues while the other queue holds an older entry for the same line.
- R7: `req_blocked` is registered. It is 1 in the cycle after a queue becomes full or a miss entry reaches TGT_MAX targets. While it is 1, requests are ignored.
- R8: `iss_size` is LINE_BYTES for cached requests and writebacks, and `req_size` for uncached reads and writes.
- R9: `iss_valid` reflects the stored queues only. The shown entry is removed at a rising edge where `iss_ready` is 1, and stays otherwise.
- R10: After reset, both queues are empty, `iss_valid` is 0 and `req_blocked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request class code (see R2) |
| req_line | input | LINE_W | Line address of the request |
| req_size | input | SIZE_W | Byte count for uncached requests |
| req_blocked | output | 1 | Request side must hold off |
| iss_valid | output | 1 | An entry is offered to the lower level |
| iss_ready | input | 1 | Lower level takes the offered entry |
| iss_write | output | 1 | Offered entry comes from the write queue |
| iss_line | output | LINE_W | Line address of the offered entry |
| iss_size | output | SIZE_W | Access size in bytes |
| iss_order | output | ORD_W | Sequence number of the offered entry |
| iss_tgts | output | TGT_W | Number of requests served by the entry |

## Verification
The assertions assume that the request side honours `req_blocked`, which the block enforces itself by ignoring requests. They also assume that the span of live sequence numbers stays below half the number range. The default depths and target limit guarantee this span. The stimulus presents at most one request per cycle and holds `iss_ready` low while it builds up queue contents. This lets merging, full-queue preference and cross-queue line hazards appear before draining. A long sweep then runs with the lower level always ready, so the queues never hold more than one entry while sequence numbers wrap.

// File: rtl/mic_pkg.sv
package mic_pkg;
    typedef enum logic [2:0] {
        RK_CACHED_RD = 3'd0,
        RK_CACHED_WR = 3'd1,
        RK_UNCACH_RD = 3'd2,
        RK_UNCACH_WR = 3'd3,
        RK_WRITEBACK = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MSHR = 2'd1,
        SRC_WBUF = 2'd2
    } issue_src_e;
endpackage

// File: rtl/mic_queue.sv
module mic_queue #(
    parameter int DEPTH   = 4,
    parameter int LINE_W  = 4,
    parameter int SIZE_W  = 4,
    parameter int ORD_W   = 5,
    parameter int TGT_MAX = 3,
    parameter bit MERGE   = 1'b1,
    parameter int NPROBE  = 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int TGT_W  = $clog2(TGT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              push_cached_i,
    input  logic              merge_en_i,
    input  logic [LINE_W-1:0] push_line_i,
    input  logic [SIZE_W-1:0] push_size_i,
    input  logic [ORD_W-1:0]  push_ord_i,
    input  logic              pop_i,
    output logic              head_vld_o,
    output logic [LINE_W-1:0] head_line_o,
    output logic [SIZE_W-1:0] head_size_o,
    output logic [ORD_W-1:0]  head_ord_o,
    output logic [TGT_W-1:0]  head_tgts_o,
    input  logic [LINE_W-1:0] probe_line_i [NPROBE],
    input  logic [ORD_W-1:0]  probe_ord_i  [NPROBE],
    output logic [NPROBE-1:0] probe_hit_o,
    output logic              full_o,
    output logic              stall_nxt_o
);
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [LINE_W-1:0] line_n [DEPTH];
    logic [SIZE_W-1:0] size_q [DEPTH];
    logic [SIZE_W-1:0] size_n [DEPTH];
    logic [ORD_W-1:0]  ord_q  [DEPTH];
    logic [ORD_W-1:0]  ord_n  [DEPTH];
    logic [TGT_W-1:0]  tgts_q [DEPTH];
    logic [TGT_W-1:0]  tgts_n [DEPTH];
    logic              cch_q  [DEPTH];
    logic              cch_n  [DEPTH];
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              merged;
    logic              tgt_lim_n;

    function automatic logic is_older(input logic [ORD_W-1:0] a, input logic [ORD_W-1:0] b);
        logic [ORD_W-1:0] d;
        d = a - b;
        return d[ORD_W-1];
    endfunction

    // next state: pop shifts toward the head, then push merges or appends
    always_comb begin
        line_n = line_q;
        size_n = size_q;
        ord_n  = ord_q;
        tgts_n = tgts_q;
        cch_n  = cch_q;
        cnt_n  = cnt_q;
        merged = 1'b0;
        if (pop_i && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                line_n[i] = line_q[i+1];
                size_n[i] = size_q[i+1];
                ord_n[i]  = ord_q[i+1];
                tgts_n[i] = tgts_q[i+1];
                cch_n[i]  = cch_q[i+1];
            end
            cnt_n = cnt_q - 1'b1;
        end
        if (push_i) begin
            if (MERGE && merge_en_i) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!merged && CNT_W'(i) < cnt_n && cch_n[i] &&
                        line_n[i] == push_line_i && tgts_n[i] < TGT_W'(TGT_MAX)) begin
                        tgts_n[i] = tgts_n[i] + 1'b1;
                        merged    = 1'b1;
                    end
                end
            end
            if (!merged) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == cnt_n) begin
                        line_n[i] = push_line_i;
                        size_n[i] = push_size_i;
                        ord_n[i]  = push_ord_i;
                        tgts_n[i] = TGT_W'(1);
                        cch_n[i]  = push_cached_i;
                    end
                end
                if (cnt_n < CNT_W'(DEPTH)) cnt_n = cnt_n + 1'b1;
            end
        end
    end

    always_comb begin
        tgt_lim_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < cnt_n && tgts_n[i] == TGT_W'(TGT_MAX)) tgt_lim_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
                size_q[i] <= '0;
                ord_q[i]  <= '0;
                tgts_q[i] <= '0;
                cch_q[i]  <= 1'b0;
            end
        end else begin
            cnt_q  <= cnt_n;
            line_q <= line_n;
            size_q <= size_n;
            ord_q  <= ord_n;
            tgts_q <= tgts_n;
            cch_q  <= cch_n;
        end
    end

    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) < cnt_q && line_q[i] == probe_line_i[p] &&
                    is_older(ord_q[i], probe_ord_i[p])) hit = 1'b1;
            end
        end
        assign probe_hit_o[p] = hit;
    end

    assign head_vld_o  = (cnt_q != '0);
    assign head_line_o = line_q[0];
    assign head_size_o = size_q[0];
    assign head_ord_o  = ord_q[0];
    assign head_tgts_o = tgts_q[0];
    assign full_o      = (cnt_q == CNT_W'(DEPTH));
    assign stall_nxt_o = (cnt_n == CNT_W'(DEPTH)) || (MERGE && tgt_lim_n);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(DEPTH) && !pop_i) |-> !push_i);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> cnt_q != '0);
endmodule

// File: rtl/miss_issue_ctrl.sv
module miss_issue_ctrl
    import mic_pkg::*;
#(
    parameter int MSHR_DEPTH = 4,
    parameter int WBUF_DEPTH = 2,
    parameter int TGT_MAX    = 3,
    parameter int LINE_W     = 4,
    parameter int LINE_BYTES = 8,
    parameter int ORD_W      = 5,
    localparam int SIZE_W    = $clog2(LINE_BYTES + 1),
    localparam int TGT_W     = $clog2(TGT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [LINE_W-1:0] req_line,
    input  logic [SIZE_W-1:0] req_size,
    output logic              req_blocked,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic              iss_write,
    output logic [LINE_W-1:0] iss_line,
    output logic [SIZE_W-1:0] iss_size,
    output logic [ORD_W-1:0]  iss_order,
    output logic [TGT_W-1:0]  iss_tgts
);
    logic [ORD_W-1:0]  ord_q;
    logic              blk_q;
    logic              acc, to_mshr, cached_rw, uncached;
    logic [SIZE_W-1:0] push_size;
    issue_src_e        sel;

    logic              m_vld, m_full, m_stall;
    logic [LINE_W-1:0] m_line;
    logic [SIZE_W-1:0] m_size;
    logic [ORD_W-1:0]  m_ord;
    logic [TGT_W-1:0]  m_tgts;
    logic [0:0]        m_hit;
    logic [LINE_W-1:0] m_pl [1];
    logic [ORD_W-1:0]  m_po [1];

    logic              w_vld, w_full, w_stall;
    logic [LINE_W-1:0] w_line;
    logic [SIZE_W-1:0] w_size;
    logic [ORD_W-1:0]  w_ord;
    logic [TGT_W-1:0]  w_tgts;
    logic [1:0]        w_hit;
    logic [LINE_W-1:0] w_pl [2];
    logic [ORD_W-1:0]  w_po [2];

    logic m_ok, w_ok;

    assign acc       = req_valid && !blk_q && (req_kind <= RK_WRITEBACK);
    assign to_mshr   = (req_kind <= RK_UNCACH_RD);
    assign cached_rw = (req_kind == RK_CACHED_RD) || (req_kind == RK_CACHED_WR);
    assign uncached  = (req_kind == RK_UNCACH_RD) || (req_kind == RK_UNCACH_WR);
    assign push_size = uncached ? req_size : SIZE_W'(LINE_BYTES);

    // miss queue is probed with the write head; write queue with the miss head
    // and with the incoming line (every live number is older than ord_q)
    assign m_pl[0] = w_line;
    assign m_po[0] = w_ord;
    assign w_pl[0] = m_line;
    assign w_po[0] = m_ord;
    assign w_pl[1] = req_line;
    assign w_po[1] = ord_q;

    mic_queue #(
        .DEPTH(MSHR_DEPTH), .LINE_W(LINE_W), .SIZE_W(SIZE_W), .ORD_W(ORD_W),
        .TGT_MAX(TGT_MAX), .MERGE(1'b1), .NPROBE(1)
    ) i_mshr_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(acc && to_mshr), .push_cached_i(cached_rw),
        .merge_en_i(cached_rw && !w_hit[1]),
        .push_line_i(req_line), .push_size_i(push_size), .push_ord_i(ord_q),
        .pop_i(sel == SRC_MSHR && iss_ready),
        .head_vld_o(m_vld), .head_line_o(m_line), .head_size_o(m_size),
        .head_ord_o(m_ord), .head_tgts_o(m_tgts),
        .probe_line_i(m_pl), .probe_ord_i(m_po), .probe_hit_o(m_hit),
        .full_o(m_full), .stall_nxt_o(m_stall)
    );

    mic_queue #(
        .DEPTH(WBUF_DEPTH), .LINE_W(LINE_W), .SIZE_W(SIZE_W), .ORD_W(ORD_W),
        .TGT_MAX(TGT_MAX), .MERGE(1'b0), .NPROBE(2)
    ) i_wbuf_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(acc && !to_mshr), .push_cached_i(1'b0), .merge_en_i(1'b0),
        .push_line_i(req_line), .push_size_i(push_size), .push_ord_i(ord_q),
        .pop_i(sel == SRC_WBUF && iss_ready),
        .head_vld_o(w_vld), .head_line_o(w_line), .head_size_o(w_size),
        .head_ord_o(w_ord), .head_tgts_o(w_tgts),
        .probe_line_i(w_pl), .probe_ord_i(w_po), .probe_hit_o(w_hit),
        .full_o(w_full), .stall_nxt_o(w_stall)
    );

    assign m_ok = m_vld && !w_hit[0];
    assign w_ok = w_vld && !m_hit[0];

    // selection
    always_comb begin
        sel = SRC_NONE;
        if (w_full && w_ok)  sel = SRC_WBUF;
        else if (m_ok)       sel = SRC_MSHR;
        else if (w_ok)       sel = SRC_WBUF;
    end

    // outputs of the selection
    always_comb begin
        iss_valid = 1'b0;
        iss_write = 1'b0;
        iss_line  = '0;
        iss_size  = '0;
        iss_order = '0;
        iss_tgts  = '0;
        unique case (sel)
            SRC_MSHR: begin
                iss_valid = 1'b1;
                iss_line  = m_line;
                iss_size  = m_size;
                iss_order = m_ord;
                iss_tgts  = m_tgts;
            end
            SRC_WBUF: begin
                iss_valid = 1'b1;
                iss_write = 1'b1;
                iss_line  = w_line;
                iss_size  = w_size;
                iss_order = w_ord;
                iss_tgts  = w_tgts;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ord_q <= '0;
            blk_q <= 1'b0;
        end else begin
            if (acc) ord_q <= ord_q + 1'b1;
            blk_q <= m_stall || w_stall;
        end
    end

    assign req_blocked = blk_q;

    // R1
    ord_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ord_q == ORD_W'($past(ord_q) + 1'b1));

    // R7
    blocked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_blocked) |=> $stable(ord_q));

    // R3
    tgts_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_tgts != '0 && iss_tgts <= TGT_W'(TGT_MAX)));
endmodule

// File: tb/test_miss_issue_ctrl.sv
`timescale 1ns/1ps
module test_miss_issue_ctrl;
    localparam int LINE_W = 4;
    localparam int SIZE_W = 4;
    localparam int ORD_W  = 5;
    localparam int TGT_W  = 2;
    localparam int LBYTES = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              req_blocked, iss_valid, iss_write;
    logic              iss_ready = 1'b0;
    logic [LINE_W-1:0] iss_line;
    logic [SIZE_W-1:0] iss_size;
    logic [ORD_W-1:0]  iss_order;
    logic [TGT_W-1:0]  iss_tgts;

    int n_cmp = 0;
    int n_bad = 0;
    int nxt_ord = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    miss_issue_ctrl i_miss_issue_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_line(req_line), .req_size(req_size), .req_blocked(req_blocked),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_write(iss_write),
        .iss_line(iss_line), .iss_size(iss_size), .iss_order(iss_order),
        .iss_tgts(iss_tgts)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic push(input int kind, input int line, input int size, input bit take);
        req_valid = 1'b1;
        req_kind  = 3'(kind);
        req_line  = LINE_W'(line);
        req_size  = SIZE_W'(size);
        @(negedge clk);
        req_valid = 1'b0;
        if (take) nxt_ord = (nxt_ord + 1) % 32;
    endtask

    task automatic expect_iss(input string tag, input int wr, input int line,
                              input int size, input int ord, input int tgts);
        iss_ready = 1'b1;
        check({tag, " valid"}, int'(iss_valid), 1);
        check({tag, " write"}, int'(iss_write), wr);
        check({tag, " line"},  int'(iss_line), line);
        check({tag, " size"},  int'(iss_size), size);
        check({tag, " order"}, int'(iss_order), ord % 32);
        check({tag, " tgts"},  int'(iss_tgts), tgts);
        @(negedge clk);
        iss_ready = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int o;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid after reset", int'(iss_valid), 0);
        check("R10 blocked after reset", int'(req_blocked), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 valid idle", int'(iss_valid), 0);

        // R4 R8: arrival order inside the miss queue, sizes
        o = nxt_ord;
        push(0, 3, 1, 1);
        push(1, 4, 2, 1);
        push(2, 5, 6, 1);
        expect_iss("R4 first",  0, 3, LBYTES, o,     1);
        expect_iss("R4 second", 0, 4, LBYTES, o + 1, 1);
        expect_iss("R8 uncached read", 0, 5, 6, o + 2, 1);
        check("R9 drained", int'(iss_valid), 0);

        // R3 R7: merge up to the limit, then blocked; blocked request ignored
        o = nxt_ord;
        push(0, 5, 0, 1);
        push(1, 5, 0, 1);
        push(0, 5, 0, 1);
        check("R7 blocked at target limit", int'(req_blocked), 1);
        push(0, 6, 0, 0);
        check("R7 still blocked", int'(req_blocked), 1);
        expect_iss("R3 merged entry", 0, 5, LBYTES, o, 3);
        check("R7 ignored request absent", int'(iss_valid), 0);
        check("R7 unblocked after issue", int'(req_blocked), 0);

        // R2: illegal kind dropped
        push(5, 2, 0, 0);
        check("R2 dropped kind", int'(iss_valid), 0);

        // R5 R7 R8: write queue full wins, then miss queue preferred
        o = nxt_ord;
        push(2, 1, 2, 1);
        push(3, 2, 3, 1);
        push(4, 3, 0, 1);
        check("R7 blocked on full write queue", int'(req_blocked), 1);
        expect_iss("R5 full write queue first", 1, 2, 3, o + 1, 1);
        check("R7 unblocked", int'(req_blocked), 0);
        expect_iss("R5 miss preferred", 0, 1, 2, o, 1);
        expect_iss("R8 writeback size", 1, 3, LBYTES, o + 2, 1);

        // R6: older write to the same line goes before a preferred miss
        o = nxt_ord;
        push(3, 9, 4, 1);
        push(0, 9, 0, 1);
        expect_iss("R6 older write first", 1, 9, 4, o, 1);
        expect_iss("R6 miss after", 0, 9, LBYTES, o + 1, 1);

        // R3 R6: merge refused when the write queue holds the line
        o = nxt_ord;
        push(0, 7, 0, 1);
        push(3, 7, 4, 1);
        push(1, 7, 0, 1);
        expect_iss("R6 oldest miss", 0, 7, LBYTES, o, 1);
        expect_iss("R6 write between", 1, 7, 4, o + 1, 1);
        expect_iss("R3 unmerged write miss", 0, 7, LBYTES, o + 2, 1);
        check("R9 empty", int'(iss_valid), 0);

        // R1 R2 R8 sweep over kinds, lines, sizes with wrap of numbers
        iss_ready = 1'b1;
        for (int i = 0; i < 40; i++) begin
            int k, sz, ex_sz;
            k = i % 5;
            sz = (i % 8) + 1;
            ex_sz = (k == 2 || k == 3) ? sz : LBYTES;
            o = nxt_ord;
            push(k, i % 16, sz, 1);
            check("R1 sweep order", int'(iss_order), o);
            check("R2 sweep write", int'(iss_write), (k >= 3) ? 1 : 0);
            check("R8 sweep size", int'(iss_size), ex_sz);
            check("R9 sweep valid", int'(iss_valid), 1);
        end
        @(negedge clk);
        iss_ready = 1'b0;
        check("R9 sweep drained", int'(iss_valid), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule